// File: doc/BRIEF.md
# Infrared Run-Length Pulse Encoder

This block turns the output of an infrared receiver module into a stream of run-length bytes. It samples the single-bit receiver line at a fixed fraction of the module clock. Each stretch of constant level becomes one byte: a level flag, plus the number of samples in the stretch minus one. Upstream of the run counter, the line is synchronized and can be inverted, for receiver modules that drive low while light is present. A noise filter then removes short glitches. A downstream buffer or decoder recovers pulse and space durations by multiplying each byte's count field by the sample period.

A packet starts at the first accepted pulse. It ends after the line has rested in the space state for a programmable number of full-length space bytes. At that point a one-cycle packet-end strobe is raised together with the last byte, and the block stays silent until the next pulse. Runs that exceed the count field are split into several bytes of the same level.

The byte stream uses a valid/ready pair. A byte is held, unchanged, until the consumer accepts it. The block never stalls its sampling, so the consumer must accept each byte within one sample period. A byte produced while an earlier one is still waiting is discarded.

Top module: `ir_runlen_enc`

## Requirements
- R1: While enabled, the line is sampled once every DIV module clocks, so a level held for K·DIV clocks accounts for exactly K samples in the codes.
- R2: Each code carries the run level in bit 7 (1 = pulse, 0 = space) and the run length in samples minus one in bits 6:0.
- R3: When `invert` is 1, the synchronized input is complemented before filtering, so a low receiver output is reported as a pulse.
- R4: A level change lasting no more than `noise_thr` samples is absorbed into the surrounding run. A change lasting `noise_thr`+1 samples is accepted, and the sum of all run lengths still equals the number of samples taken.
- R5: A run longer than 128 samples is emitted as one code with count field 127, followed by further codes of the same level for the rest of the run.
- R6: Each full-length space code counts one idle unit. The code that completes `idle_thr`+1 such units is output with `pkt_end` high for one cycle. After that no code is produced until the next pulse.
- R7: The block operates only when `glob_en`, `rx_en` and `mode` = 2'b11 all hold. Otherwise it produces no code and no `pkt_end`, and its run state is cleared.
- R8: While `code_valid` is high and `code_ready` is low, `code_valid` stays high and `code_data` stays constant. A code produced during that time is discarded.
- R9: After reset, `code_valid` and `pkt_end` are 0.
- R10: Space seen before the first pulse of a packet produces no code. The first accepted pulse starts a new packet with a fresh run count and idle count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| glob_en | input | 1 | Global enable |
| rx_en | input | 1 | Receive path enable |
| mode | input | 2 | Operating mode; 2'b11 selects run-length capture |
| invert | input | 1 | Complement the input line before filtering |
| noise_thr | input | 6 | Longest change, in samples, treated as noise |
| idle_thr | input | 8 | Full-length space codes after the first that end a packet |
| ir_in | input | 1 | Asynchronous receiver line |
| code_valid | output | 1 | Run-length code available |
| code_ready | input | 1 | Consumer accepts the code |
| code_data | output | 8 | Level in bit 7, length minus one in bits 6:0 |
| pkt_end | output | 1 | One-cycle strobe raised with the code that ends a packet |

## Verification
The bench targets the following corner cases and the failure each one would expose:
- **Lost or extra samples.** A design that lost or added a sample when the filter accepts a transition would shift run counts by one, including on the first run of a packet.
- **Glitch at the threshold.** A glitch exactly `noise_thr` samples long must merge into its neighbours. A filter with an off-by-one compare would split that run into three codes.
- **Long runs.** A 200-sample pulse checks that the split happens at 128 and not 127, and that the split does not touch the idle count.
- **Packet end and restart.** With an idle threshold of 2, `pkt_end` must fire on the third full space code and not earlier. A design that failed to clear the idle count on a new packet would end the next packet too soon.
- **Back-pressure.** Holding `code_ready` low must keep the first byte intact. A design that overwrote the pending byte with the newer codes would deliver the wrong byte.

// File: rtl/irle_pkg.sv
package irle_pkg;
  localparam int RUN_W = 7;
  localparam logic [1:0] MODE_RUNLEN = 2'b11;
  localparam logic [RUN_W-1:0] RUN_FULL = '1;
  typedef logic [RUN_W:0] rl_code_t;

  function automatic rl_code_t pack_code(input logic lvl, input logic [RUN_W-1:0] len_m1);
    return {lvl, len_m1};
  endfunction
endpackage

// File: rtl/irle_tick_gen.sv
module irle_tick_gen #(
  parameter int DIV = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick_o
);
  generate
    if (DIV <= 1) begin : g_pass
      assign tick_o = en;
    end else begin : g_div
      localparam int CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt_q <= '0;
        else if (!en)          cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                   cnt_q <= cnt_q + 1'b1;
      end

      assign tick_o = en && (cnt_q == LAST);

      AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o); // R1
    end
  endgenerate
endmodule

// File: rtl/irle_sync_filter.sv
module irle_sync_filter #(
  parameter int NOISE_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               tick,
  input  logic               invert,
  input  logic [NOISE_W-1:0] noise_thr,
  input  logic               raw_i,
  output logic               lvl_o
);
  logic               s1_q, s2_q;
  logic               flt_q;
  logic [NOISE_W-1:0] nz_q;
  logic               smp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= raw_i;
      s2_q <= s1_q;
    end
  end

  assign smp = s2_q ^ invert;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt_q <= 1'b0;
      nz_q  <= '0;
    end else if (!en) begin
      flt_q <= 1'b0;
      nz_q  <= '0;
    end else if (tick) begin
      if (smp == flt_q) begin
        nz_q <= '0;
      end else if (nz_q >= noise_thr) begin
        flt_q <= smp;
        nz_q  <= '0;
      end else begin
        nz_q <= nz_q + 1'b1;
      end
    end
  end

  assign lvl_o = flt_q;

  AST_FILTER_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_q != $past(flt_q)) |-> ($past(tick) || !$past(en))); // R4
endmodule

// File: rtl/irle_run_coder.sv
module irle_run_coder
  import irle_pkg::*;
#(
  parameter int IDLE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tick,
  input  logic              lvl,
  input  logic [IDLE_W-1:0] idle_thr,
  output logic              emit_o,
  output rl_code_t          code_o,
  output logic              pkt_end_o
);
  logic             active_q;
  logic             cur_q;
  logic [RUN_W-1:0] cnt_q;
  logic [IDLE_W-1:0] idle_q;
  logic             full;

  assign full   = (cnt_q == RUN_FULL);
  assign code_o = pack_code(cur_q, cnt_q);

  always_comb begin
    emit_o    = 1'b0;
    pkt_end_o = 1'b0;
    if (en && tick && active_q) begin
      if (lvl != cur_q) begin
        emit_o = 1'b1;
      end else if (full) begin
        emit_o    = 1'b1;
        pkt_end_o = !cur_q && (idle_q == idle_thr);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cur_q    <= 1'b0;
      cnt_q    <= '0;
      idle_q   <= '0;
    end else if (!en) begin
      active_q <= 1'b0;
      cur_q    <= 1'b0;
      cnt_q    <= '0;
      idle_q   <= '0;
    end else if (tick) begin
      if (!active_q) begin
        if (lvl) begin
          active_q <= 1'b1;
          cur_q    <= 1'b1;
          cnt_q    <= '0;
          idle_q   <= '0;
        end
      end else if (lvl != cur_q) begin
        cur_q  <= lvl;
        cnt_q  <= '0;
        idle_q <= '0;
      end else if (full) begin
        cnt_q <= '0;
        if (!cur_q) begin
          if (pkt_end_o) active_q <= 1'b0;
          else           idle_q   <= idle_q + 1'b1;
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  AST_IDLE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_end_o |=> !active_q); // R6
  AST_NO_EMIT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q |-> !emit_o); // R10
endmodule

// File: rtl/ir_runlen_enc.sv
module ir_runlen_enc
  import irle_pkg::*;
#(
  parameter int DIV     = 64,
  parameter int NOISE_W = 6,
  parameter int IDLE_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               glob_en,
  input  logic               rx_en,
  input  logic [1:0]         mode,
  input  logic               invert,
  input  logic [NOISE_W-1:0] noise_thr,
  input  logic [IDLE_W-1:0]  idle_thr,
  input  logic               ir_in,
  output logic               code_valid,
  input  logic               code_ready,
  output logic [7:0]         code_data,
  output logic               pkt_end
);
  logic     run_en;
  logic     tick;
  logic     flt_lvl;
  logic     c_emit;
  logic     c_pe;
  rl_code_t c_code;

  assign run_en = glob_en && rx_en && (mode == MODE_RUNLEN);

  irle_tick_gen #(.DIV(DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .en(run_en), .tick_o(tick)
  );

  irle_sync_filter #(.NOISE_W(NOISE_W)) u_filt (
    .clk(clk), .rst_n(rst_n), .en(run_en), .tick(tick), .invert(invert),
    .noise_thr(noise_thr), .raw_i(ir_in), .lvl_o(flt_lvl)
  );

  irle_run_coder #(.IDLE_W(IDLE_W)) u_coder (
    .clk(clk), .rst_n(rst_n), .en(run_en), .tick(tick), .lvl(flt_lvl),
    .idle_thr(idle_thr), .emit_o(c_emit), .code_o(c_code), .pkt_end_o(c_pe)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_valid <= 1'b0;
      code_data  <= '0;
      pkt_end    <= 1'b0;
    end else if (!run_en) begin
      code_valid <= 1'b0;
      pkt_end    <= 1'b0;
    end else begin
      pkt_end <= c_pe;
      if (code_valid && code_ready) code_valid <= 1'b0;
      if (c_emit && (!code_valid || code_ready)) begin
        code_data  <= c_code;
        code_valid <= 1'b1;
      end
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (code_valid && !code_ready && run_en) |=> (code_valid && $stable(code_data))); // R8
  AST_PE_WITH_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_end |-> code_valid); // R6
  AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (!code_valid && !pkt_end)); // R7
endmodule

// File: tb/tb_ir_runlen_enc.sv
`timescale 1ns/1ps
module tb_ir_runlen_enc;
  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       glob_en = 1'b0, rx_en = 1'b0, invert = 1'b0, ir_in = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [5:0] noise_thr = '0;
  logic [7:0] idle_thr = '0;
  logic       code_valid, code_ready = 1'b1, pkt_end;
  logic [7:0] code_data;
  logic       inv_drive = 1'b0;

  int n_chk = 0, n_fail = 0, pe_cnt = 0;
  bit done = 0;
  logic [7:0] got[$];
  logic [7:0] exp_q[$];

  always #2 clk = ~clk;

  ir_runlen_enc #(.DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .glob_en(glob_en), .rx_en(rx_en), .mode(mode),
    .invert(invert), .noise_thr(noise_thr), .idle_thr(idle_thr), .ir_in(ir_in),
    .code_valid(code_valid), .code_ready(code_ready), .code_data(code_data),
    .pkt_end(pkt_end)
  );

  always @(negedge clk) begin
    if (code_valid && code_ready) got.push_back(code_data);
    if (pkt_end) pe_cnt++;
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic seg(input logic lvl, input int n);
    for (int i = 0; i < n * DIV; i++) begin
      ir_in = lvl ^ inv_drive;
      @(negedge clk);
    end
  endtask

  task automatic cmp_codes(input string req, input int exp_pe);
    check({req, " code count"}, got.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got.size(); i++)
      check({req, " code value"}, got[i], exp_q[i]);
    check({req, " pkt_end count"}, pe_cnt, exp_pe);
  endtask

  task automatic start(input logic inv, input int nthr, input int ithr);
    glob_en = 1'b0;
    repeat (4) @(negedge clk);
    got.delete(); exp_q.delete(); pe_cnt = 0;
    invert = inv; inv_drive = inv; noise_thr = 6'(nthr); idle_thr = 8'(ithr);
    ir_in = inv; mode = 2'b11; rx_en = 1'b1;
    repeat (4) @(negedge clk);
    glob_en = 1'b1;
  endtask

  task automatic t_reset;
    check("R9 code_valid after reset", code_valid, 0);
    check("R9 pkt_end after reset", pkt_end, 0);
  endtask

  task automatic t_basic; // R1 R2 R10
    start(1'b0, 0, 0);
    seg(0, 10); seg(1, 5); seg(0, 3); seg(1, 2); seg(0, 140);
    exp_q = '{8'h84, 8'h02, 8'h81, 8'h7F};
    cmp_codes("R1 R2 R10 basic", 1);
  endtask

  task automatic t_invert; // R3
    start(1'b1, 0, 0);
    seg(0, 6); seg(1, 7); seg(0, 4); seg(1, 1); seg(0, 140);
    exp_q = '{8'h86, 8'h03, 8'h80, 8'h7F};
    cmp_codes("R3 invert", 1);
  endtask

  task automatic t_noise; // R4
    start(1'b0, 2, 0);
    seg(0, 10); seg(1, 6); seg(0, 5); seg(1, 4); seg(0, 2); seg(1, 4); seg(0, 140);
    exp_q = '{8'h85, 8'h04, 8'h89, 8'h7F};
    cmp_codes("R4 noise", 1);
  endtask

  task automatic t_split; // R5
    start(1'b0, 0, 0);
    seg(0, 5); seg(1, 200); seg(0, 3); seg(1, 1); seg(0, 140);
    exp_q = '{8'hFF, 8'hC7, 8'h02, 8'h80, 8'h7F};
    cmp_codes("R5 split", 1);
  endtask

  task automatic t_idle; // R6 R10
    start(1'b0, 0, 2);
    seg(0, 5); seg(1, 3); seg(0, 400);
    exp_q = '{8'h82, 8'h7F, 8'h7F, 8'h7F};
    cmp_codes("R6 idle end", 1);
    seg(0, 200);
    check("R6 silent after pkt_end", got.size(), 4);
    seg(1, 4); seg(0, 140);
    exp_q = '{8'h82, 8'h7F, 8'h7F, 8'h7F, 8'h83, 8'h7F};
    cmp_codes("R10 restart", 1);
  endtask

  task automatic t_disable; // R7
    start(1'b0, 0, 0);
    mode = 2'b10;
    seg(0, 5); seg(1, 5); seg(0, 140);
    check("R7 wrong mode codes", got.size(), 0);
    mode = 2'b11; glob_en = 1'b0;
    seg(1, 5); seg(0, 140);
    check("R7 global off codes", got.size(), 0);
    glob_en = 1'b1; rx_en = 1'b0;
    seg(1, 5); seg(0, 140);
    check("R7 rx off codes", got.size(), 0);
    check("R7 pkt_end count", pe_cnt, 0);
  endtask

  task automatic t_backpressure; // R8
    start(1'b0, 0, 0);
    code_ready = 1'b0;
    seg(0, 5); seg(1, 3); seg(0, 2); seg(1, 2); seg(0, 3);
    check("R8 valid held", code_valid, 1);
    check("R8 data held", code_data, 8'h82);
    repeat (20) @(negedge clk);
    check("R8 data stable", code_data, 8'h82);
    code_ready = 1'b1;
    seg(0, 140);
    exp_q = '{8'h82, 8'h7F};
    cmp_codes("R8 drop while pending", 1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_basic();
    t_invert();
    t_noise();
    t_split();
    t_idle();
    t_disable();
    t_backpressure();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule